// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

This block gathers up to 64 device interrupt request lines into one pending-request register and steers them to up to four processors. Each processor owns a 64-bit enable mask. Its routed register is the bitwise AND of that mask with the pending requests. Each processor receives one level-sensitive interrupt output, which stays high while any of its routed bits is set. Devices raise and drop their lines with one-cycle set and clear pulses, one bit per line. Software programs the masks and inspects the state through a small register port. That port carries a byte offset, a width flag (64-bit or 32-bit) and 64-bit write data.

Registers sit in 64-byte slots, so the slot index is the byte offset shifted right by six and the low six offset bits are ignored. A small response state machine registers the outcome of every access. It has three states. `RSP_IDLE` means no response. `RSP_DATA` means read data is presented. `RSP_FAULT` means the access was refused. Every cycle the machine takes one of three transitions: `go_data` on a legal read, `go_fault` on an unsupported access, and `go_idle` on a legal write or when no access is made. Each state lasts exactly one cycle unless a new access arrives.

Top module: `irq_router`

## Requirements
- R1: After reset, all masks, routed registers and the request register are zero, every `cpu_irq` bit is low, `reg_rdata` is zero and `reg_err` is low.
- R2: The slot index is `reg_offset >> 6`. Slot n (n = 0..3) is the mask of processor n. Slot 4+n is the routed register of processor n. Slot 8 is the request register. The low six offset bits have no effect.
- R3: A 64-bit write to a mask slot replaces the whole mask of that processor, and the new value reads back afterwards.
- R4: Each routed register always equals its processor's mask ANDed with the request register, reflecting every mask write and device event from the next cycle on.
- R5: A `dev_set` bit sets the matching request bit. When `dev_set` and `dev_clr` hit the same bit in the same cycle, the set wins.
- R6: A `dev_clr` bit clears a pending request bit. A clear aimed at a bit that is not pending changes nothing.
- R7: `cpu_irq[n]` is high exactly when routed register n is non-zero, one cycle after the causing event. A mask write that unroutes the last pending bit drops the line.
- R8: A legal read returns its data on `reg_rdata` in the cycle after the access. The data is the register value before any update made in the same cycle. At all other times `reg_rdata` is zero.
- R9: The request register also accepts a 32-bit read (`reg_wide` = 0), which returns its bits 31:0 zero-extended. All other slots accept only 64-bit (`reg_wide` = 1) accesses.
- R10: An unsupported access is refused. Unsupported means a write to a routed or request slot, a 32-bit access to any slot but a read of slot 8, or any access to a slot above 8 or to a mask slot of an absent processor. A refused access changes no state, returns zero data and pulses `reg_err` for one cycle, one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_offset | input | AW (12) | Byte offset from the block base |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the access |
| reg_err | output | 1 | One-cycle refusal flag, one cycle after the access |
| dev_set | input | NLINES (64) | Per-line request set pulses |
| dev_clr | input | NLINES (64) | Per-line request clear pulses |
| cpu_irq | output | NCPU (4) | Per-processor level interrupt |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This applies to the read data, the refusal flag, and the interrupt levels after a mask write or device pulse. The bench drives each stimulus at a falling edge and updates its behavioural model at the following rising edge. It then compares all outputs at the next falling edge. Read expectations are taken from the model before it applies the same cycle's updates, so a read sharing a cycle with a device pulse or mask write is checked against the old value.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int DW          = 64;
    localparam int SLOT_SHIFT  = 6;
    localparam int MAX_CPU     = 4;
    localparam int SLOT_MASK0  = 0;
    localparam int SLOT_ROUTE0 = 4;
    localparam int SLOT_REQ    = 8;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_DATA,
        RSP_FAULT
    } rsp_state_e;

    typedef enum logic [1:0] {
        KIND_MASK,
        KIND_ROUTE,
        KIND_REQ,
        KIND_NONE
    } slot_kind_e;

endpackage

// File: rtl/req_bank.sv
module req_bank #(
    parameter int NLINES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] dev_set,
    input  logic [NLINES-1:0] dev_clr,
    output logic [NLINES-1:0] req_q,
    output logic [NLINES-1:0] req_next
);

    logic [NLINES-1:0] clr_eff;

    always_comb begin
        clr_eff  = dev_clr & req_q & ~dev_set;
        req_next = (req_q | dev_set) & ~clr_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_next;
    end

    assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_set != '0) |=> ((req_q & $past(dev_set)) == $past(dev_set)));

    assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_set == '0 && dev_clr == '0) |=> $stable(req_q));

    assert_clear_only_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_set == '0) |=> ((req_q & ~$past(req_q)) == '0));

endmodule

// File: rtl/cpu_route.sv
module cpu_route #(
    parameter int NLINES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [NLINES-1:0] mask_wdata,
    input  logic [NLINES-1:0] req_next,
    output logic [NLINES-1:0] mask_q,
    output logic [NLINES-1:0] routed_q,
    output logic              irq_q
);

    logic [NLINES-1:0] mask_next;
    logic [NLINES-1:0] routed_next;

    always_comb begin
        mask_next   = mask_we ? mask_wdata : mask_q;
        routed_next = mask_next & req_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            routed_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            mask_q   <= mask_next;
            routed_q <= routed_next;
            irq_q    <= |routed_next;
        end
    end

    assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_wdata)));

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (routed_q != '0));

    assert_route_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (routed_q & ~mask_q) == '0);

endmodule

// File: rtl/access_fsm.sv
module access_fsm
    import irq_router_pkg::*;
#(
    parameter int AW     = 12,
    parameter int NCPU   = 4,
    parameter int NLINES = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_valid,
    input  logic                         reg_write,
    input  logic [AW-1:0]                reg_offset,
    input  logic                         reg_wide,
    input  logic [NCPU-1:0][NLINES-1:0]  masks,
    input  logic [NCPU-1:0][NLINES-1:0]  routed,
    input  logic [NLINES-1:0]            req,
    output logic [NCPU-1:0]              mask_we,
    output logic [DW-1:0]                reg_rdata,
    output logic                         reg_err
);

    localparam int IW = AW - SLOT_SHIFT;

    logic [IW-1:0] slot;
    slot_kind_e    kind;
    logic          legal;
    logic [DW-1:0] sel_data;
    logic [DW-1:0] req_ext;
    rsp_state_e    state_q, state_next;
    logic [DW-1:0] data_q, data_next;

    always_comb begin
        slot = IW'(reg_offset >> SLOT_SHIFT);
        if (int'(slot) < SLOT_MASK0 + NCPU)
            kind = KIND_MASK;
        else if (int'(slot) >= SLOT_ROUTE0 && int'(slot) < SLOT_ROUTE0 + NCPU)
            kind = KIND_ROUTE;
        else if (int'(slot) == SLOT_REQ)
            kind = KIND_REQ;
        else
            kind = KIND_NONE;

        unique case (kind)
            KIND_MASK:  legal = reg_wide;
            KIND_ROUTE: legal = reg_wide && !reg_write;
            KIND_REQ:   legal = !reg_write;
            default:    legal = 1'b0;
        endcase
    end

    always_comb begin
        req_ext           = '0;
        req_ext[NLINES-1:0] = req;
        sel_data          = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (int'(slot) == SLOT_MASK0 + c)  sel_data[NLINES-1:0] = masks[c];
            if (int'(slot) == SLOT_ROUTE0 + c) sel_data[NLINES-1:0] = routed[c];
        end
        if (kind == KIND_REQ)
            sel_data = reg_wide ? req_ext : {32'b0, req_ext[31:0]};
    end

    always_comb begin
        for (int c = 0; c < NCPU; c++)
            mask_we[c] = reg_valid && reg_write && legal &&
                         kind == KIND_MASK && int'(slot) == SLOT_MASK0 + c;
    end

    always_comb begin
        data_next  = '0;
        state_next = RSP_IDLE;
        if (reg_valid) begin
            if (!legal) begin
                state_next = RSP_FAULT;
            end else if (!reg_write) begin
                state_next = RSP_DATA;
                data_next  = sel_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_next;
            data_q  <= data_next;
        end
    end

    always_comb begin
        reg_rdata = '0;
        reg_err   = 1'b0;
        unique case (state_q)
            RSP_IDLE:  ;
            RSP_DATA:  reg_rdata = data_q;
            RSP_FAULT: reg_err   = 1'b1;
            default:   ;
        endcase
    end

    assert_err_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_err && !$past(reg_valid)) |-> 1'b0);

    assert_mask_we_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_we));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int AW     = 12,
    parameter int NCPU   = 4,
    parameter int NLINES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [AW-1:0]     reg_offset,
    input  logic              reg_wide,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              reg_err,
    input  logic [NLINES-1:0] dev_set,
    input  logic [NLINES-1:0] dev_clr,
    output logic [NCPU-1:0]   cpu_irq
);

    logic [NLINES-1:0]            req_q;
    logic [NLINES-1:0]            req_next;
    logic [NCPU-1:0][NLINES-1:0]  masks;
    logic [NCPU-1:0][NLINES-1:0]  routed;
    logic [NCPU-1:0]              mask_we;

    req_bank #(.NLINES(NLINES)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_set  (dev_set),
        .dev_clr  (dev_clr),
        .req_q    (req_q),
        .req_next (req_next)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        cpu_route #(.NLINES(NLINES)) u_route (
            .clk        (clk),
            .rst_n      (rst_n),
            .mask_we    (mask_we[c]),
            .mask_wdata (reg_wdata[NLINES-1:0]),
            .req_next   (req_next),
            .mask_q     (masks[c]),
            .routed_q   (routed[c]),
            .irq_q      (cpu_irq[c])
        );

        assert_routed_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
            routed[c] == (masks[c] & req_q));
    end

    access_fsm #(.AW(AW), .NCPU(NCPU), .NLINES(NLINES)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_offset (reg_offset),
        .reg_wide   (reg_wide),
        .masks      (masks),
        .routed     (routed),
        .req        (req_q),
        .mask_we    (mask_we),
        .reg_rdata  (reg_rdata),
        .reg_err    (reg_err)
    );

    assert_fault_keeps_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $stable(masks));

    assert_fault_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> (reg_rdata == '0));

endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_valid = 1'b0;
    logic          reg_write = 1'b0;
    logic [AW-1:0] reg_offset = '0;
    logic          reg_wide = 1'b1;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   reg_rdata;
    logic          reg_err;
    logic [63:0]   dev_set = '0;
    logic [63:0]   dev_clr = '0;
    logic [3:0]    cpu_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [63:0] m_mask [4];
    logic [63:0] m_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router #(.AW(AW), .NCPU(4), .NLINES(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_offset(reg_offset), .reg_wide(reg_wide), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .dev_set(dev_set),
        .dev_clr(dev_clr), .cpu_irq(cpu_irq)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    // One cycle: drive at falling edge, model at rising edge, compare at next falling edge.
    task automatic step(input logic v, input logic w, input logic [AW-1:0] off,
                        input logic wide, input logic [63:0] wd,
                        input logic [63:0] set, input logic [63:0] clr,
                        input string tag);
        int          slot;
        bit          legal;
        logic [63:0] exp_rd;
        logic        exp_err;
        logic [3:0]  exp_irq;
        reg_valid = v; reg_write = w; reg_offset = off; reg_wide = wide;
        reg_wdata = wd; dev_set = set; dev_clr = clr;
        slot = int'(off >> 6);
        if (slot <= 3)      legal = wide;
        else if (slot <= 7) legal = wide && !w;
        else if (slot == 8) legal = !w;
        else                legal = 0;
        exp_rd = '0;
        exp_err = v && !legal;
        if (v && legal && !w) begin
            if (slot <= 3)      exp_rd = m_mask[slot];
            else if (slot <= 7) exp_rd = m_mask[slot-4] & m_req;
            else                exp_rd = wide ? m_req : {32'b0, m_req[31:0]};
        end
        @(posedge clk);
        if (v && legal && w) m_mask[slot] = wd;
        m_req = (m_req | set) & ~(clr & m_req & ~set);
        for (int c = 0; c < 4; c++) exp_irq[c] = |(m_mask[c] & m_req);
        @(negedge clk);
        check(tag, "rdata", reg_rdata, exp_rd);
        check(tag, "err", {63'b0, reg_err}, {63'b0, exp_err});
        check(tag, "irq", {60'b0, cpu_irq}, {60'b0, exp_irq});
    endtask

    task automatic idle(input string tag);
        step(0, 0, '0, 1, '0, '0, '0, tag);
    endtask

    task automatic rd(input logic [AW-1:0] off, input logic wide, input string tag);
        step(1, 0, off, wide, '0, '0, '0, tag);
    endtask

    task automatic wr(input logic [AW-1:0] off, input logic wide,
                      input logic [63:0] d, input string tag);
        step(1, 1, off, wide, d, '0, '0, tag);
    endtask

    task automatic pulse(input logic [63:0] set, input logic [63:0] clr, input string tag);
        step(0, 0, '0, 1, '0, set, clr, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 4; c++) m_mask[c] = '0;
        m_req = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state through every readable slot
        idle("R1");
        for (int s = 0; s <= 8; s++) rd(AW'(s << 6), 1, "R1");

        // R2, R3: mask load and readback with low offset bits ignored
        wr(12'h000, 1, 64'h0000_0000_0000_00F0, "R3");
        rd(12'h013, 1, "R2");
        wr(12'h0C5, 1, 64'h8000_0000_0000_0001, "R2");
        rd(12'h0C0, 1, "R3");

        // R5, R7: device set raises routed processors
        pulse(64'h10, '0, "R5");
        rd(12'h100, 1, "R4");
        rd(12'h200, 1, "R5");
        pulse(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R5");
        rd(12'h1C0, 1, "R4");

        // R7: mask write withdraws routing and drops line
        wr(12'h000, 1, 64'h0, "R7");
        wr(12'h000, 1, 64'h10, "R7");

        // R6: spurious clear, then real clear
        pulse('0, 64'h200, "R6");
        rd(12'h200, 1, "R6");
        pulse('0, 64'h10, "R6");
        rd(12'h200, 1, "R6");

        // R9: 32-bit request read hides upper bits
        pulse(64'h0000_0100_0000_0004, '0, "R9");
        rd(12'h200, 0, "R9");
        rd(12'h200, 1, "R9");

        // R8: read sharing a cycle with a device pulse returns the old value
        step(1, 0, 12'h200, 1, '0, 64'h40, '0, "R8");
        rd(12'h200, 1, "R8");

        // R10: refused accesses
        wr(12'h100, 1, 64'hFFFF, "R10");
        wr(12'h200, 1, 64'hFFFF, "R10");
        rd(12'h040, 0, "R10");
        wr(12'h000, 0, 64'hFFFF, "R10");
        rd(12'h400, 1, "R10");
        rd(12'h000, 1, "R10");
        rd(12'h100, 1, "R10");

        // R4: mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] off;
            logic [63:0]   s, k, d;
            off = AW'(($urandom_range(0, 10) << 6) | $urandom_range(0, 63));
            s = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            k = {$urandom, $urandom} & {$urandom, $urandom};
            d = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) s = '0;
            step($urandom_range(0, 1), $urandom_range(0, 1), off,
                 ($urandom_range(0, 7) != 0), d, s, k, "R4");
        end
        idle("R7");
        finish_run();
    end

endmodule